// File: doc/BRIEF.md
# Programmable Panel Sync Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB panel, together with the current dot and line position. It advances one dot per clock. Software programs the frame geometry through four configuration words and two polarity inputs. Each configuration word carries two fields: one in the low half and one in the high half, which starts at bit CFG_W/2. Horizontal fields count in groups of 8 dots, so a field value N means 8·N dots. Vertical fields count whole lines.

A line starts with the visible region. The front porch follows, then the sync pulse, then the back porch. Frames use the same order with lines in place of dots. A run input starts and stops the generator. A two-bit status output walks from 0 up to 3 one frame at a time after a start, and walks back down to 0 after a stop. Software polls this status to learn when the panel is fully driven or fully quiet. The generator copies the geometry and polarity into shadow registers only when a frame begins. A reprogramming write made in the middle of a frame therefore never splits that frame.

Top module: `lcd_sync_gen`

## Requirements
- R1: After reset, `pwr_stat` is 0, `x_pos` and `y_pos` are 0, and `de`, `hsync` and `vsync` are 0 while both polarity inputs are 0.
- R2: A line lasts 8 × (low half of `h_count_cfg`) dots. `x_pos` counts from 0 up to that length minus 1 and then returns to 0.
- R3: `de` is 1 exactly when `x_pos` < 8 × (high half of `h_count_cfg`) and `y_pos` < (high half of `v_line_cfg`). `de` is never 1 while `pwr_stat` is 0.
- R4: `hsync` is asserted when `x_pos` ≥ 8 × (low half of `h_sync_cfg`) and `x_pos` < 8 × (low half + high half of `h_sync_cfg`). This holds when the front porch or the back porch is zero.
- R5: A frame lasts (low half of `v_line_cfg`) lines. `y_pos` increments when `x_pos` wraps to 0, and returns to 0 after the last line. `y_pos` does not change while `x_pos` is nonzero.
- R6: `vsync` is asserted for the whole of every line with `y_pos` ≥ (low half of `v_sync_cfg`) and `y_pos` < (low half + high half of `v_sync_cfg`).
- R7: When `hs_active_low` is 1, the asserted level of `hsync` is 0 and its idle level is 1. `vs_active_low` controls `vsync` in the same way.
- R8: When `run` rises while `pwr_stat` is 0, the first frame starts with `pwr_stat` = 1. The status is 2 at the next frame start and 3 at the one after, and then stays at 3.
- R9: While `run` is 0, `pwr_stat` drops by one at each frame boundary. Once it reaches 0, `x_pos`, `y_pos` and `de` stay at 0 and both syncs sit at their idle level.
- R10: The configuration words and polarity inputs take effect only from the next frame start. A write made in the middle of a frame leaves the frame in progress unchanged.
- R11: Raising `run` again while the status is still falling makes the status rise again, by one per frame boundary, starting from its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | 1 requests output, 0 requests stop |
| h_count_cfg | input | CFG_W | Low half: line length /8. High half: visible width /8 |
| h_sync_cfg | input | CFG_W | Low half: sync start /8. High half: sync width /8 |
| v_line_cfg | input | CFG_W | Low half: lines per frame. High half: visible lines |
| v_sync_cfg | input | CFG_W | Low half: sync start line. High half: sync width in lines |
| hs_active_low | input | 1 | 1 makes hsync active-low |
| vs_active_low | input | 1 | 1 makes vsync active-low |
| hsync | output | 1 | Horizontal sync, registered |
| vsync | output | 1 | Vertical sync, registered |
| de | output | 1 | Data enable, registered |
| x_pos | output | CFG_W/2+3 | Current dot within the line |
| y_pos | output | CFG_W/2 | Current line within the frame |
| pwr_stat | output | 2 | Power status, 0 to 3 |

## Verification
The hardest case to reach is a change of direction in the status walk. The bench starts output, lowers `run` after two frames and raises it again before the status reaches 0. It then expects the status to rise from the value it had reached. A second hard case is a mid-frame reprogramming write. The bench writes a shorter geometry in the middle of a frame. It confirms that the frame in progress still reaches the old maximum dot, and that the following frame follows the new geometry. That new geometry has zero front porch and zero back porch, so the sync window touches both edges of the line.

// File: rtl/lsg_pkg.sv
package lsg_pkg;
  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_WAKE1 = 2'd1,
    PS_WAKE2 = 2'd2,
    PS_ON    = 2'd3
  } pwr_e;
endpackage

// File: rtl/lsg_axis.sv
// One timing axis: position counter plus region decode.
module lsg_axis #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] tot,
  input  logic [CNT_W-1:0] act,
  input  logic [CNT_W-1:0] sp,
  input  logic [CNT_W-1:0] sw,
  output logic [CNT_W-1:0] pos,
  output logic             last,
  output logic             in_act,
  output logic             in_sync
);
  logic [CNT_W:0] pos_x, sp_x, end_x;

  always_comb begin
    pos_x   = {1'b0, pos};
    sp_x    = {1'b0, sp};
    end_x   = {1'b0, sp} + {1'b0, sw};
    last    = (pos == tot - 1'b1);
    in_act  = (pos < act);
    in_sync = (pos_x >= sp_x) && (pos_x < end_x);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      pos <= '0;
    else if (step)
      pos <= last ? '0 : pos + 1'b1;
  end
endmodule

// File: rtl/lsg_power.sv
// Run/stop sequencer: status walks one step per frame boundary.
module lsg_power
  import lsg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic frame_end,
  output pwr_e stat,
  output logic load
);
  always_comb load = ((stat == PS_OFF) && run) || frame_end;

  always_ff @(posedge clk) begin
    if (rst)
      stat <= PS_OFF;
    else if (stat == PS_OFF) begin
      if (run) stat <= PS_WAKE1;
    end else if (frame_end) begin
      if (run && stat != PS_ON)
        stat <= pwr_e'(stat + 2'd1);
      else if (!run)
        stat <= pwr_e'(stat - 2'd1);
    end
  end
endmodule

// File: rtl/lsg_shadow.sv
// Frame-synchronous copy of the timing words and polarity.
module lsg_shadow #(
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CFG_W-1:0] hc_in,
  input  logic [CFG_W-1:0] hs_in,
  input  logic [CFG_W-1:0] vl_in,
  input  logic [CFG_W-1:0] vs_in,
  input  logic             hpol_in,
  input  logic             vpol_in,
  output logic [CFG_W-1:0] hc_q,
  output logic [CFG_W-1:0] hs_q,
  output logic [CFG_W-1:0] vl_q,
  output logic [CFG_W-1:0] vs_q,
  output logic             hpol_q,
  output logic             vpol_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hc_q <= '0; hs_q <= '0; vl_q <= '0; vs_q <= '0;
      hpol_q <= 1'b0; vpol_q <= 1'b0;
    end else if (load) begin
      hc_q <= hc_in; hs_q <= hs_in; vl_q <= vl_in; vs_q <= vs_in;
      hpol_q <= hpol_in; vpol_q <= vpol_in;
    end
  end
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lsg_pkg::*;
#(
  parameter int CFG_W = 32,
  localparam int FLD_W = CFG_W / 2,
  localparam int HX_W  = FLD_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CFG_W-1:0] h_count_cfg,
  input  logic [CFG_W-1:0] h_sync_cfg,
  input  logic [CFG_W-1:0] v_line_cfg,
  input  logic [CFG_W-1:0] v_sync_cfg,
  input  logic             hs_active_low,
  input  logic             vs_active_low,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [HX_W-1:0]  x_pos,
  output logic [FLD_W-1:0] y_pos,
  output logic [1:0]       pwr_stat
);
  pwr_e stat;
  logic load, running, frame_end;
  logic [CFG_W-1:0] hc_q, hs_q, vl_q, vs_q;
  logic hpol_q, vpol_q;
  logic [HX_W-1:0]  hpos;
  logic [FLD_W-1:0] vpos;
  logic h_last, h_act, h_sync, v_last, v_act, v_sync;

  // Horizontal fields scale from 8-dot units to dots.
  function automatic logic [HX_W-1:0] dots(input logic [FLD_W-1:0] f);
    return {f, 3'b000};
  endfunction

  always_comb begin
    running   = (stat != PS_OFF);
    frame_end = running && h_last && v_last;
  end

  lsg_power u_pwr (
    .clk(clk), .rst(rst), .run(run), .frame_end(frame_end),
    .stat(stat), .load(load)
  );

  lsg_shadow #(.CFG_W(CFG_W)) u_shd (
    .clk(clk), .rst(rst), .load(load),
    .hc_in(h_count_cfg), .hs_in(h_sync_cfg),
    .vl_in(v_line_cfg), .vs_in(v_sync_cfg),
    .hpol_in(hs_active_low), .vpol_in(vs_active_low),
    .hc_q(hc_q), .hs_q(hs_q), .vl_q(vl_q), .vs_q(vs_q),
    .hpol_q(hpol_q), .vpol_q(vpol_q)
  );

  lsg_axis #(.CNT_W(HX_W)) u_h (
    .clk(clk), .rst(rst), .clr(!running), .step(running),
    .tot(dots(hc_q[FLD_W-1:0])), .act(dots(hc_q[CFG_W-1:FLD_W])),
    .sp(dots(hs_q[FLD_W-1:0])),  .sw(dots(hs_q[CFG_W-1:FLD_W])),
    .pos(hpos), .last(h_last), .in_act(h_act), .in_sync(h_sync)
  );

  lsg_axis #(.CNT_W(FLD_W)) u_v (
    .clk(clk), .rst(rst), .clr(!running), .step(running && h_last),
    .tot(vl_q[FLD_W-1:0]), .act(vl_q[CFG_W-1:FLD_W]),
    .sp(vs_q[FLD_W-1:0]),  .sw(vs_q[CFG_W-1:FLD_W]),
    .pos(vpos), .last(v_last), .in_act(v_act), .in_sync(v_sync)
  );

  // Registered output stage, all outputs aligned to the same dot.
  always_ff @(posedge clk) begin
    if (rst) begin
      x_pos <= '0; y_pos <= '0; de <= 1'b0;
      hsync <= 1'b0; vsync <= 1'b0; pwr_stat <= 2'd0;
    end else begin
      pwr_stat <= stat;
      if (running) begin
        x_pos <= hpos;
        y_pos <= vpos;
        de    <= h_act && v_act;
        hsync <= h_sync ^ hpol_q;
        vsync <= v_sync ^ vpol_q;
      end else begin
        x_pos <= '0;
        y_pos <= '0;
        de    <= 1'b0;
        hsync <= hs_active_low;
        vsync <= vs_active_low;
      end
    end
  end
endmodule

// File: rtl/lsg_checker.sv
module lsg_checker #(
  parameter int HX_W = 19,
  parameter int VY_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [HX_W-1:0] x_pos,
  input logic [VY_W-1:0] y_pos,
  input logic            de,
  input logic [1:0]      pwr_stat
);
  // R8 / R9: status moves by exactly one step per change
  a_r8_stat_single_step: assert property (@(posedge clk) disable iff (rst)
    (pwr_stat != $past(pwr_stat)) |->
      (pwr_stat == 2'($past(pwr_stat) + 2'd1)) || (pwr_stat == 2'($past(pwr_stat) - 2'd1)));

  // R8: status changes only where a frame begins
  a_r8_stat_at_frame: assert property (@(posedge clk) disable iff (rst)
    ($past(pwr_stat) != 2'd0 && pwr_stat != $past(pwr_stat)) |-> (x_pos == '0 && y_pos == '0));

  // R3: no data enable while stopped
  a_r3_de_needs_run: assert property (@(posedge clk) disable iff (rst)
    de |-> (pwr_stat != 2'd0));

  // R9: stopped generator parks at the origin
  a_r9_idle_origin: assert property (@(posedge clk) disable iff (rst)
    (pwr_stat == 2'd0) |-> (x_pos == '0 && y_pos == '0 && !de));

  // R2: dot position advances by one inside a line
  a_r2_x_advance: assert property (@(posedge clk) disable iff (rst)
    (pwr_stat != 2'd0 && $past(pwr_stat) != 2'd0 && x_pos != '0) |->
      (x_pos == HX_W'($past(x_pos) + 1'b1)));

  // R5: line number holds within a line
  a_r5_y_holds: assert property (@(posedge clk) disable iff (rst)
    (x_pos != '0) |-> $stable(y_pos));
endmodule

bind lcd_sync_gen lsg_checker #(.HX_W(HX_W), .VY_W(FLD_W)) u_chk (
  .clk(clk), .rst(rst), .x_pos(x_pos), .y_pos(y_pos),
  .de(de), .pwr_stat(pwr_stat)
);

// File: tb/tb_lcd_sync_gen.sv
module tb_lcd_sync_gen;
  localparam int CFG_W = 32;
  localparam int FLD_W = CFG_W / 2;
  localparam int HX_W  = FLD_W + 3;

  typedef struct {
    int ht, ha, hsp, hsw, vt, va, vsp, vsw;
    bit hlow, vlow;
  } cfg_t;
  typedef struct { cfg_t c; int tgt; } pend_t;

  logic clk = 1'b0, rst = 1'b1, run = 1'b0;
  logic [CFG_W-1:0] hc = '0, hs = '0, vl = '0, vs = '0;
  logic hlow = 1'b0, vlow = 1'b0;
  logic hsync, vsync, de;
  logic [HX_W-1:0] x_pos;
  logic [FLD_W-1:0] y_pos;
  logic [1:0] pwr_stat;

  always #4 clk = ~clk;

  lcd_sync_gen #(.CFG_W(CFG_W)) dut (
    .clk(clk), .rst(rst), .run(run),
    .h_count_cfg(hc), .h_sync_cfg(hs), .v_line_cfg(vl), .v_sync_cfg(vs),
    .hs_active_low(hlow), .vs_active_low(vlow),
    .hsync(hsync), .vsync(vsync), .de(de),
    .x_pos(x_pos), .y_pos(y_pos), .pwr_stat(pwr_stat)
  );

  int n_chk = 0, n_fail = 0;
  pend_t pq[$];
  int frames_seen = 0;
  event ev_frame;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Driver: program words and push the expected geometry for the next frame.
  task automatic apply(cfg_t c);
    pend_t p;
    hc = CFG_W'((c.ha << 16) | c.ht);
    hs = CFG_W'((c.hsw << 16) | c.hsp);
    vl = CFG_W'((c.va << 16) | c.vt);
    vs = CFG_W'((c.vsw << 16) | c.vsp);
    hlow = c.hlow; vlow = c.vlow;
    p.c = c; p.tgt = frames_seen + 1;
    pq.push_back(p);
  endtask

  // Monitor: reference position model, one check per field per frame.
  int mx = 0, my = 0;
  bit was_run = 0, f_open = 0;
  cfg_t cur;
  bit err[5];
  int act_v[5], exp_v[5];

  task automatic note(int k, int a, int e);
    if (a != e && !err[k]) begin err[k] = 1; act_v[k] = a; exp_v[k] = e; end
  endtask

  task automatic finalize();
    string tags[5];
    if (!f_open) return;
    tags[0] = "R2 x_pos";
    tags[1] = "R5 y_pos";
    tags[2] = "R3 de";
    tags[3] = cur.hlow ? "R7 hsync" : "R4 hsync";
    tags[4] = cur.vlow ? "R7 vsync" : "R6 vsync";
    for (int k = 0; k < 5; k++) begin
      chk(!err[k], tags[k], act_v[k], exp_v[k]);
      err[k] = 0;
    end
    f_open = 0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (pwr_stat != 2'd0) begin
        if (!was_run) begin mx = 0; my = 0; end
        if (mx == 0 && my == 0) begin
          finalize();
          frames_seen++;
          while (pq.size() > 0 && pq[0].tgt <= frames_seen) cur = pq.pop_front().c;
          f_open = 1;
          -> ev_frame;
        end
        note(0, int'(x_pos), mx);
        note(1, int'(y_pos), my);
        note(2, int'(de), int'((mx < cur.ha * 8) && (my < cur.va)));
        note(3, int'(hsync), int'(((mx >= cur.hsp * 8) && (mx < (cur.hsp + cur.hsw) * 8)) ^ cur.hlow));
        note(4, int'(vsync), int'(((my >= cur.vsp) && (my < cur.vsp + cur.vsw)) ^ cur.vlow));
        mx++;
        if (mx == cur.ht * 8) begin
          mx = 0; my++;
          if (my == cur.vt) my = 0;
        end
        was_run = 1;
      end else begin
        if (was_run) finalize();
        was_run = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    cfg_t ca, cb, cc;
    int mxx;
    ca = '{6, 4, 4, 1, 6, 4, 4, 1, 1'b0, 1'b0};
    cb = '{5, 3, 3, 2, 5, 2, 2, 2, 1'b1, 1'b1};  // zero porches on both sides
    cc = '{10, 8, 8, 1, 3, 1, 1, 1, 1'b0, 1'b0};

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pwr_stat == 0, "R1 pwr_stat", pwr_stat, 0);
    chk(x_pos == 0 && y_pos == 0, "R1 position", int'(x_pos) + int'(y_pos), 0);
    chk(!de && !hsync && !vsync, "R1 strobes", {de, hsync, vsync}, 0);

    apply(ca);
    run = 1'b1;
    @(ev_frame); chk(pwr_stat == 1, "R8 first frame", pwr_stat, 1);
    @(ev_frame); chk(pwr_stat == 2, "R8 second frame", pwr_stat, 2);
    @(ev_frame); chk(pwr_stat == 3, "R8 third frame", pwr_stat, 3);

    repeat (100) @(negedge clk);
    apply(cb);
    mxx = 0;
    repeat (60) begin @(negedge clk); if (int'(x_pos) > mxx) mxx = int'(x_pos); end
    chk(mxx == 47, "R10 frame in progress keeps length", mxx, 47);
    @(ev_frame); chk(pwr_stat == 3, "R8 stays on", pwr_stat, 3);
    mxx = 0;
    repeat (45) begin @(negedge clk); if (int'(x_pos) > mxx) mxx = int'(x_pos); end
    chk(mxx == 39, "R2 new line length", mxx, 39);

    run = 1'b0;
    @(ev_frame); chk(pwr_stat == 2, "R9 step down", pwr_stat, 2);
    @(ev_frame); chk(pwr_stat == 1, "R9 step down", pwr_stat, 1);
    repeat (250) @(negedge clk);
    chk(pwr_stat == 0, "R9 stopped", pwr_stat, 0);
    chk(x_pos == 0 && y_pos == 0 && !de, "R9 idle outputs", {de, 1'b0}, 0);
    chk(hsync && vsync, "R7 idle level active-low", {hsync, vsync}, 3);

    apply(cc);
    run = 1'b1;
    @(ev_frame); chk(pwr_stat == 1, "R8 restart", pwr_stat, 1);
    @(ev_frame); chk(pwr_stat == 2, "R8 restart", pwr_stat, 2);
    repeat (50) @(negedge clk);
    run = 1'b0;
    @(ev_frame); chk(pwr_stat == 1, "R9 fall from 2", pwr_stat, 1);
    repeat (50) @(negedge clk);
    run = 1'b1;
    @(ev_frame); chk(pwr_stat == 2, "R11 rises again", pwr_stat, 2);
    @(ev_frame); chk(pwr_stat == 3, "R11 reaches on", pwr_stat, 3);
    repeat (50) @(negedge clk);
    run = 1'b0;
    @(ev_frame); chk(pwr_stat == 2, "R9 stop", pwr_stat, 2);
    @(ev_frame); chk(pwr_stat == 1, "R9 stop", pwr_stat, 1);
    repeat (300) @(negedge clk);
    chk(pwr_stat == 0, "R9 stopped again", pwr_stat, 0);
    chk(!hsync && !vsync, "R9 idle level active-high", {hsync, vsync}, 0);
    finish_up();
  end
endmodule